// File: doc/BRIEF.md
# Cache-Line Fetch Group Extractor

This block turns one instruction-cache line and a starting program counter into a group of up to `W` instructions for the decode stage. Starting at the word that the PC selects, it walks forward through the line. Each instruction word is converted from memory byte order into the order the core uses. Each emitted slot gets a PC, a predicted next PC and a fresh sequence number.

Slots flagged as control instructions query an external branch predictor in the same cycle. A slot's PC is always the predicted next PC of the slot before it. The group stops at the first of three limits: the end of the line, `W` slots, or a control instruction that is predicted taken. That taken instruction is still part of the group.

One cycle after a line is presented, the registered group appears at the outputs. In that same cycle the block's PC and next-PC registers, the sequence counter, the taken-branch counter and a group-size histogram are updated.

Top module: `line_group_extractor`

## Requirements
- R1: `fetch_addr` equals `pc_in` with its low log2(`LINE_BYTES`) bits cleared, combinationally.
- R2: Slot 0 holds the instruction word at byte offset `pc_in mod LINE_BYTES`. Slot k holds the next word in order. With no taken branch, the group holds min(`W`, words left in the line) slots, so a start at the last word gives exactly one slot.
- R3: A group never holds more than `W` slots; with no taken branch and enough words left it holds exactly `W`.
- R4: `bp_req[k]` is high only for a valid slot whose `is_ctl[k]` is set, with `bp_pc` slot k equal to that slot's PC. On a taken answer the slot's next PC is `bp_target` slot k, the group ends after that slot, and `taken_cnt` increments by one.
- R5: For a non-control slot, or a control slot predicted not taken, the next PC is the slot PC plus 4. Slot 0's PC is `pc_in`, and each later slot's PC is the previous slot's next PC.
- R6: Valid slot k carries sequence number S+k, where S is the counter value before the group. The counter then advances by the group size.
- R7: After a group, `pc_q` holds the next PC of the last valid slot and `npc_q` holds that value plus 4.
- R8: Histogram bin n (`hist` bits [n*CNT_W +: CNT_W]) increments by one for each group of size n.
- R9: The line's byte i sits at `line_data` bits [8i+7:8i]. A slot's instruction has the byte at the word's lowest address in bits [31:24] and the byte at the highest address in bits [7:0].
- R10: After reset, `grp_valid` is 0, `grp_count` is 0, `pc_q` is 0, `npc_q` is 4, and all counters and bins are 0. A cycle without `line_valid` gives an empty group (`grp_count` 0) and leaves `pc_q`, `npc_q` and the counters unchanged.
- R11: `grp_valid` is a contiguous run of ones from bit 0 whose length equals `grp_count`. Invalid slots carry zero in every field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_valid | input | 1 | A line and start PC are presented this cycle |
| line_data | input | LINE_BYTES*8 | Cache line, byte i at bits [8i+7:8i] |
| pc_in | input | ADDR_W | Start PC, word aligned |
| is_ctl | input | W | Control-instruction flag per slot |
| fetch_addr | output | ADDR_W | Line-aligned access address |
| bp_req | output | W | Predictor query per slot |
| bp_pc | output | W*ADDR_W | PC of each queried slot |
| bp_taken | input | W | Predictor taken answer per slot |
| bp_target | input | W*ADDR_W | Predictor target per slot |
| grp_valid | output | W | Registered slot valid |
| grp_inst | output | W*32 | Registered instruction per slot |
| grp_pc | output | W*ADDR_W | Registered PC per slot |
| grp_npc | output | W*ADDR_W | Registered predicted next PC per slot |
| grp_seq | output | W*SEQ_W | Registered sequence number per slot |
| grp_count | output | $clog2(W+1) | Registered group size |
| pc_q | output | ADDR_W | PC register |
| npc_q | output | ADDR_W | Next-PC register |
| taken_cnt | output | CNT_W | Predicted-taken branch count |
| hist | output | (W+1)*CNT_W | Group-size histogram bins |

## Verification
`fetch_addr` and the predictor query outputs are combinational. The bench reads them one time unit after driving the inputs, inside the same cycle. The group fields, `pc_q`, `npc_q` and the counters are all due after exactly one rising edge. The bench therefore drives on a falling edge and compares on the next falling edge against a model that computes each group from the requirements. Idle cycles are checked on the falling edge after a cycle without `line_valid`.

// File: rtl/line_group_extractor.sv
module line_group_extractor #(
  parameter int W          = 4,
  parameter int LINE_BYTES = 64,
  parameter int ADDR_W     = 32,
  parameter int SEQ_W      = 16,
  parameter int CNT_W      = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       line_valid,
  input  logic [LINE_BYTES*8-1:0]    line_data,
  input  logic [ADDR_W-1:0]          pc_in,
  input  logic [W-1:0]               is_ctl,
  output logic [ADDR_W-1:0]          fetch_addr,
  output logic [W-1:0]               bp_req,
  output logic [W*ADDR_W-1:0]        bp_pc,
  input  logic [W-1:0]               bp_taken,
  input  logic [W*ADDR_W-1:0]        bp_target,
  output logic [W-1:0]               grp_valid,
  output logic [W*32-1:0]            grp_inst,
  output logic [W*ADDR_W-1:0]        grp_pc,
  output logic [W*ADDR_W-1:0]        grp_npc,
  output logic [W*SEQ_W-1:0]         grp_seq,
  output logic [$clog2(W+1)-1:0]     grp_count,
  output logic [ADDR_W-1:0]          pc_q,
  output logic [ADDR_W-1:0]          npc_q,
  output logic [CNT_W-1:0]           taken_cnt,
  output logic [(W+1)*CNT_W-1:0]     hist
);
  localparam int IB     = 4;
  localparam int IW     = IB * 8;
  localparam int LWORDS = LINE_BYTES / IB;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IB_W   = $clog2(IB);
  localparam int CW     = $clog2(W + 1);

  logic [W-1:0][IW-1:0]     s_inst, q_inst;
  logic [W-1:0][ADDR_W-1:0] s_pc, s_npc, q_pc, q_npc, q_bpc;
  logic [W-1:0][SEQ_W-1:0]  q_seq;
  logic [W-1:0]             s_valid, s_req;
  logic [CW-1:0]            s_cnt;
  logic [ADDR_W-1:0]        s_final;
  logic                     s_taken;
  logic [SEQ_W-1:0]         seq_q;
  logic [W:0][CNT_W-1:0]    hist_q;

  assign fetch_addr = pc_in & ~ADDR_W'(LINE_BYTES - 1);

  always_comb begin
    logic                alive;
    logic [ADDR_W-1:0]   cur, nxt;
    logic [OFF_W:0]      widx;
    logic [IW-1:0]       raw;
    logic                tk;
    alive   = 1'b1;
    cur     = pc_in;
    s_cnt   = '0;
    s_taken = 1'b0;
    for (int k = 0; k < W; k++) begin
      widx       = (OFF_W+1)'(pc_in[OFF_W-1:IB_W]) + (OFF_W+1)'(k);
      s_valid[k] = alive && (widx < (OFF_W+1)'(LWORDS));
      raw        = line_data[(s_valid[k] ? int'(widx) : 0) * IW +: IW];
      for (int b = 0; b < IB; b++)
        s_inst[k][IW-1-8*b -: 8] = s_valid[k] ? raw[8*b +: 8] : 8'h00;
      q_bpc[k]   = cur;
      s_req[k]   = s_valid[k] && is_ctl[k];
      tk         = s_req[k] && bp_taken[k];
      nxt        = tk ? bp_target[k*ADDR_W +: ADDR_W] : cur + ADDR_W'(IB);
      s_pc[k]    = s_valid[k] ? cur : '0;
      s_npc[k]   = s_valid[k] ? nxt : '0;
      if (s_valid[k]) begin
        cur   = nxt;
        s_cnt = s_cnt + CW'(1);
      end
      if (tk) s_taken = 1'b1;
      alive = s_valid[k] && !tk;
    end
    s_final = cur;
  end

  assign bp_req = s_req;
  assign bp_pc  = q_bpc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_valid <= '0;
      grp_count <= '0;
      q_inst    <= '0;
      q_pc      <= '0;
      q_npc     <= '0;
      q_seq     <= '0;
      pc_q      <= '0;
      npc_q     <= ADDR_W'(IB);
      seq_q     <= '0;
      taken_cnt <= '0;
    end else if (line_valid) begin
      grp_valid <= s_valid;
      grp_count <= s_cnt;
      q_inst    <= s_inst;
      q_pc      <= s_pc;
      q_npc     <= s_npc;
      for (int k = 0; k < W; k++)
        q_seq[k] <= s_valid[k] ? seq_q + SEQ_W'(k) : '0;
      pc_q      <= s_final;
      npc_q     <= s_final + ADDR_W'(IB);
      seq_q     <= seq_q + SEQ_W'(s_cnt);
      if (s_taken) taken_cnt <= taken_cnt + CNT_W'(1);
    end else begin
      grp_valid <= '0;
      grp_count <= '0;
      q_inst    <= '0;
      q_pc      <= '0;
      q_npc     <= '0;
      q_seq     <= '0;
    end
  end

  genvar n;
  generate
    for (n = 0; n <= W; n++) begin : g_bin
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q[n] <= '0;
        else if (line_valid && s_cnt == CW'(n)) hist_q[n] <= hist_q[n] + CNT_W'(1);
      end
    end
  endgenerate

  assign grp_inst = q_inst;
  assign grp_pc   = q_pc;
  assign grp_npc  = q_npc;
  assign grp_seq  = q_seq;
  assign hist     = hist_q;

  AST_REQ_ONLY_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_req & ~is_ctl) == '0) else $error("bp_req without control flag"); // R4
  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grp_valid) == int'(grp_count)) else $error("count mismatch"); // R11
  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |=> seq_q == $past(seq_q) + SEQ_W'(grp_count)) else $error("seq step"); // R6
  AST_NPC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |=> npc_q == pc_q + ADDR_W'(IB)) else $error("npc step"); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_valid |=> $stable(pc_q) && $stable(taken_cnt) && grp_count == '0) else $error("idle"); // R10
  AST_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |=> grp_valid[0]) else $error("empty group"); // R2
endmodule

// File: tb/sim_line_group_extractor.sv
`timescale 1ns/1ps
module sim_line_group_extractor;
  localparam int W = 4, LB = 64, AW = 32, SW = 16, CN = 16, CWD = 3;
  logic clk = 0, rst_n = 0, line_valid = 0;
  logic [LB*8-1:0] line_data = '0;
  logic [AW-1:0] pc_in = '0;
  logic [W-1:0] is_ctl = '0, bp_req, bp_taken, grp_valid;
  logic [AW-1:0] fetch_addr, pc_q, npc_q;
  logic [W*AW-1:0] bp_pc, bp_target, grp_pc, grp_npc;
  logic [W*32-1:0] grp_inst;
  logic [W*SW-1:0] grp_seq;
  logic [CWD-1:0] grp_count;
  logic [CN-1:0] taken_cnt;
  logic [(W+1)*CN-1:0] hist;
  int mode = 0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  line_group_extractor u0 (.*);

  function automatic logic pred_tk(logic [AW-1:0] p, int m);
    if (m == 1) return 1'b1;
    if (m == 2) return 1'b0;
    return p[3] ^ p[6] ^ p[9];
  endfunction
  function automatic logic [AW-1:0] pred_tg(logic [AW-1:0] p);
    return p ^ 32'h0000_2A40;
  endfunction

  always_comb
    for (int k = 0; k < W; k++) begin
      bp_taken[k] = pred_tk(bp_pc[k*AW +: AW], mode);
      bp_target[k*AW +: AW] = pred_tg(bp_pc[k*AW +: AW]);
    end

  logic [AW-1:0] e_pc[W], e_npc[W];
  logic [31:0] e_inst[W];
  logic [SW-1:0] e_seq[W];
  logic [W-1:0] e_valid;
  int e_cnt;
  logic [SW-1:0] m_seq = 0;
  logic [CN-1:0] m_taken = 0;
  logic [CN-1:0] m_hist[W+1];
  logic [AW-1:0] m_pc = 0, m_npc = 4;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model();
    logic [AW-1:0] cur = pc_in;
    int w = int'(pc_in[5:2]);
    logic stop = 0, tk_any = 0;
    e_cnt = 0; e_valid = '0;
    for (int k = 0; k < W; k++) begin
      e_pc[k] = 0; e_npc[k] = 0; e_inst[k] = 0; e_seq[k] = 0;
      if (!stop && w + k < LB/4) begin
        logic tk = is_ctl[k] && pred_tk(cur, mode);
        e_valid[k] = 1; e_pc[k] = cur; e_seq[k] = m_seq + SW'(k);
        for (int b = 0; b < 4; b++)
          e_inst[k][31-8*b -: 8] = line_data[((w+k)*4+b)*8 +: 8];
        e_npc[k] = tk ? pred_tg(cur) : cur + 4;
        cur = e_npc[k]; e_cnt++;
        if (tk) begin stop = 1; tk_any = 1; end
      end
    end
    m_seq += SW'(e_cnt); m_pc = cur; m_npc = cur + 4;
    if (tk_any) m_taken++;
    m_hist[e_cnt]++;
  endtask

  task automatic run_group(logic [AW-1:0] pc, logic [W-1:0] ctl, int m);
    pc_in = pc; is_ctl = ctl; mode = m; line_valid = 1;
    #1;
    chk("R1 fetch_addr", fetch_addr, pc & ~32'h3F);
    model();
    for (int k = 0; k < W; k++) begin
      chk("R4 bp_req", bp_req[k], e_valid[k] & ctl[k]);
      if (e_valid[k] && ctl[k]) chk("R4 bp_pc", bp_pc[k*AW +: AW], e_pc[k]);
    end
    @(negedge clk);
    chk("R2 R3 grp_count", grp_count, e_cnt);
    chk("R11 grp_valid", grp_valid, e_valid);
    for (int k = 0; k < W; k++) begin
      chk("R9 inst", grp_inst[k*32 +: 32], e_inst[k]);
      chk("R5 pc", grp_pc[k*AW +: AW], e_pc[k]);
      chk("R4 R5 npc", grp_npc[k*AW +: AW], e_npc[k]);
      chk("R6 seq", grp_seq[k*SW +: SW], e_seq[k]);
    end
    chk("R7 pc_q", pc_q, m_pc);
    chk("R7 npc_q", npc_q, m_npc);
    chk("R4 taken_cnt", taken_cnt, m_taken);
  endtask

  task automatic rand_line();
    for (int i = 0; i < LB/4; i++) line_data[i*32 +: 32] = $urandom;
  endtask

  task automatic idle_cycle();
    logic [AW-1:0] p = pc_q;
    line_valid = 0;
    @(negedge clk);
    chk("R10 idle count", grp_count, 0);
    chk("R10 idle valid", grp_valid, 0);
    chk("R10 idle pc", pc_q, p);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i <= W; i++) m_hist[i] = 0;
    #22 rst_n = 1;
    @(negedge clk);
    chk("R10 reset valid", grp_valid, 0);
    chk("R10 reset count", grp_count, 0);
    chk("R10 reset pc", pc_q, 0);
    chk("R10 reset npc", npc_q, 4);
    chk("R10 reset taken", taken_cnt, 0);
    for (int i = 0; i < LB; i++) line_data[i*8 +: 8] = 8'(i);
    run_group(32'h0000_1000, 4'b0000, 2);  // R9 R3 full width
    chk("R9 byte order", grp_inst[31:0], 32'h00010203);
    run_group(32'h0000_203C, 4'b0000, 2);  // R2 last word
    run_group(32'h0000_2034, 4'b0000, 2);  // R2 three left
    run_group(32'h0000_3000, 4'b0001, 1);  // R4 taken at slot 0
    run_group(32'h0000_3010, 4'b1000, 1);  // R4 taken at last slot
    run_group(32'h0000_3020, 4'b1111, 2);  // R5 not taken
    idle_cycle();
    for (int it = 0; it < 400; it++) begin
      rand_line();
      run_group(($urandom % 2) ? pc_q : ($urandom & 32'hFFFF_FFFC),
                4'($urandom), int'($urandom % 3));
      if (it % 37 == 0) idle_cycle();
    end
    idle_cycle();
    for (int i = 0; i <= W; i++) chk("R8 hist", hist[i*CN +: CN], m_hist[i]);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule